// File: doc/BRIEF.md
# Split Column and Peripheral Repair Allocator

This block hands out redundancy to the defects that a memory self-test finds. Two spare pools exist. One holds spare bitcell columns. The other holds spare peripheral slices, meaning a sense-amplifier and write-driver path. Each defect arrives on a valid/ready handshake as a column index plus a type bit that says bitcell or peripheral. One cycle later the block answers with a repaired or unrepairable flag. It also keeps running counts of spares used in each pool and of defects it could not repair.

A policy input chooses how spares are spent. In the tied policy, a column spare replaces the whole column, cells and peripheral alike, whatever actually failed. In the split policy, a peripheral defect takes only a peripheral spare and a cell defect takes only a column spare. This stretches the same redundancy over more defects.

A lookup port reads the remap table by column and returns a valid bit and a spare index for each pool. A small steering mux provides the test-mode bypass. It can route the data-in stage, the write-driver output or the normal array read onto the data output, so a failure can be placed on one side or the other of the array boundary.

Top module: `rr_repair_alloc`

## Requirements
- R1: A defect is taken when dfx_valid and dfx_ready are both high at a rising edge. Exactly one res_valid pulse follows, in the next cycle, and res_valid is never high otherwise.
- R2: With policy_split=1, a defect with dfx_periph=0 (bitcell) on a column that has no column spare takes the next column spare. A defect with dfx_periph=1 (peripheral) takes the next peripheral spare instead. Each pool hands out indices 0, 1, 2, ... in order, and neither pool's count changes on a cycle with no accepted defect.
- R3: A further defect that needs the same pool on a column that already holds a spare from that pool is reported repaired and takes no new spare. With policy_split=1, a bitcell defect and a peripheral defect on one column take one spare from each pool.
- R4: With policy_split=0, every defect draws on the column pool. A newly assigned column shows valid entries with the same index in both the column and peripheral halves of the lookup. The peripheral pool count does not change.
- R5: A defect whose pool is empty gets res_repaired=0 and increments unrep_cnt by one. It leaves no new table entry.
- R6: Each pool holds NUM_COLS/SPARE_RATIO spares (16 at the defaults), and neither used count exceeds that.
- R7: The lookup is registered. One cycle after lk_col is presented, lk_arr_valid/lk_arr_idx and lk_per_valid/lk_per_idx give that column's entries.
- R8: A defect taken with dfx_last=1 produces done together with its result. From then until reset dfx_ready is low, and further dfx_valid has no effect on results or counts.
- R9: After reset dfx_ready=1, res_valid=0, done=0, all counts are 0 and every lookup entry is invalid.
- R10: byp_mode selects dq_out combinationally: 00 normal read (sa_out), 01 data-in loop (io_din), 10 peripheral-only path skipping the array (wd_out), 11 full path through array and peripheral (sa_out).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_split | input | 1 | 1 = split pools, 0 = tied column spare |
| dfx_valid | input | 1 | Defect offered |
| dfx_ready | output | 1 | Block accepts a defect |
| dfx_col | input | CW | Column index of the defect |
| dfx_periph | input | 1 | 1 = peripheral defect, 0 = bitcell defect |
| dfx_last | input | 1 | Marks the final defect of the run |
| res_valid | output | 1 | Result for one defect |
| res_repaired | output | 1 | 1 = repaired, 0 = unrepairable |
| done | output | 1 | Pulse with the result of the final defect |
| used_arr | output | CNTW | Column spares in use |
| used_per | output | CNTW | Peripheral spares in use |
| unrep_cnt | output | CW+1 | Unrepairable defects so far |
| lk_col | input | CW | Lookup column |
| lk_arr_valid | output | 1 | Column spare assigned |
| lk_arr_idx | output | SW | Column spare index |
| lk_per_valid | output | 1 | Peripheral spare assigned |
| lk_per_idx | output | SW | Peripheral spare index |
| byp_mode | input | 2 | Bypass test mode |
| io_din | input | DW | Data-in stage value |
| wd_out | input | DW | Write-driver output |
| sa_out | input | DW | Sense-amplifier read output |
| dq_out | output | DW | Steered data output |

## Verification
The flag, done and counters come from registers updated at the edge that accepts a defect. So the bench drives a defect at a falling edge and compares them at the next falling edge, half a cycle after the edge that loaded them. The lookup result is also due one edge after lk_col is applied, and it is sampled at the following falling edge. The bypass output is combinational and is sampled one nanosecond after its inputs change. The scoreboard queues each expected flag when the defect is driven and pops it only on a res_valid, so a late, missing or extra result is caught.

// File: rtl/rr_pkg.sv
package rr_pkg;
   typedef enum logic [1:0] {
      BYP_OFF    = 2'd0,
      BYP_IO     = 2'd1,
      BYP_PERIPH = 2'd2,
      BYP_FULL   = 2'd3
   } byp_mode_e;

   localparam int POOL_ARR  = 0;
   localparam int POOL_PER  = 1;
   localparam int NUM_POOLS = 2;
endpackage

// File: rtl/rr_spare_pool.sv
module rr_spare_pool #(
   parameter int DEPTH = 16,
   localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   output logic [SW-1:0]   next_idx,
   output logic [CNTW-1:0] used,
   output logic            empty
);
   logic [CNTW-1:0] used_q;

   assign empty    = (used_q == CNTW'(DEPTH));
   assign next_idx = used_q[SW-1:0];
   assign used     = used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q <= '0;
      end else if (take && !empty) begin
         used_q <= used_q + 1'b1;
      end
   end
endmodule

// File: rtl/rr_remap_table.sv
module rr_remap_table #(
   parameter int NUM_COLS = 512,
   parameter int SW       = 4,
   localparam int CW      = $clog2(NUM_COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [CW-1:0] wr_col,
   input  logic [SW-1:0] wr_idx,
   input  logic [CW-1:0] chk_col,
   output logic          chk_valid,
   input  logic [CW-1:0] lk_col,
   output logic          lk_valid,
   output logic [SW-1:0] lk_idx
);
   logic [NUM_COLS-1:0] vld_q;
   logic [SW-1:0]       idx_mem [NUM_COLS];

   assign chk_valid = vld_q[chk_col];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q    <= '0;
         lk_valid <= 1'b0;
      end else begin
         if (wr_en) vld_q[wr_col] <= 1'b1;
         lk_valid <= vld_q[lk_col];
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) idx_mem[wr_col] <= wr_idx;
      lk_idx <= idx_mem[lk_col];
   end
endmodule

// File: rtl/rr_bypass_steer.sv
module rr_bypass_steer #(
   parameter int DW = 32
) (
   input  logic [1:0]    mode,
   input  logic [DW-1:0] io_din,
   input  logic [DW-1:0] wd_out,
   input  logic [DW-1:0] sa_out,
   output logic [DW-1:0] dq_out
);
   import rr_pkg::*;

   byp_mode_e sel;
   assign sel = byp_mode_e'(mode);

   always_comb begin
      case (sel)
         BYP_IO:     dq_out = io_din;
         BYP_PERIPH: dq_out = wd_out;
         BYP_FULL:   dq_out = sa_out;
         default:    dq_out = sa_out;
      endcase
   end
endmodule

// File: rtl/rr_repair_alloc.sv
module rr_repair_alloc #(
   parameter int NUM_COLS    = 512,
   parameter int SPARE_RATIO = 32,
   parameter int DW          = 32,
   localparam int NSP        = NUM_COLS / SPARE_RATIO,
   localparam int CW         = $clog2(NUM_COLS),
   localparam int SW         = (NSP > 1) ? $clog2(NSP) : 1,
   localparam int CNTW       = $clog2(NSP + 1),
   localparam int UW         = CW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            policy_split,
   input  logic            dfx_valid,
   output logic            dfx_ready,
   input  logic [CW-1:0]   dfx_col,
   input  logic            dfx_periph,
   input  logic            dfx_last,
   output logic            res_valid,
   output logic            res_repaired,
   output logic            done,
   output logic [CNTW-1:0] used_arr,
   output logic [CNTW-1:0] used_per,
   output logic [UW-1:0]   unrep_cnt,
   input  logic [CW-1:0]   lk_col,
   output logic            lk_arr_valid,
   output logic [SW-1:0]   lk_arr_idx,
   output logic            lk_per_valid,
   output logic [SW-1:0]   lk_per_idx,
   input  logic [1:0]      byp_mode,
   input  logic [DW-1:0]   io_din,
   input  logic [DW-1:0]   wd_out,
   input  logic [DW-1:0]   sa_out,
   output logic [DW-1:0]   dq_out
);
   import rr_pkg::*;

   if ((NUM_COLS & (NUM_COLS - 1)) != 0 || NUM_COLS < 4) begin : g_bad_cols
      $error("NUM_COLS must be a power of two, at least 4");
   end
   if (NUM_COLS % SPARE_RATIO != 0 || NSP < 2) begin : g_bad_ratio
      $error("SPARE_RATIO must divide NUM_COLS leaving at least two spares");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [NUM_POOLS-1:0] take, empty, hit, wr_en, lk_v;
   logic [SW-1:0]        nidx   [NUM_POOLS];
   logic [SW-1:0]        wr_idx [NUM_POOLS];
   logic [SW-1:0]        lk_i   [NUM_POOLS];
   logic [CNTW-1:0]      used   [NUM_POOLS];

   for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
      rr_spare_pool #(.DEPTH(NSP)) u_pool (
         .clk      (clk),
         .rst_n    (rst_n),
         .take     (take[p]),
         .next_idx (nidx[p]),
         .used     (used[p]),
         .empty    (empty[p])
      );
      rr_remap_table #(.NUM_COLS(NUM_COLS), .SW(SW)) u_tab (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_en[p]),
         .wr_col    (dfx_col),
         .wr_idx    (wr_idx[p]),
         .chk_col   (dfx_col),
         .chk_valid (hit[p]),
         .lk_col    (lk_col),
         .lk_valid  (lk_v[p]),
         .lk_idx    (lk_i[p])
      );
   end

   logic closed_q, acc, repaired;
   logic res_valid_q, res_rep_q, done_q;
   logic [UW-1:0] unrep_q;

   assign dfx_ready = !closed_q;
   assign acc       = dfx_valid && dfx_ready;

   always_comb begin
      take     = '0;
      wr_en    = '0;
      repaired = 1'b0;
      for (int p = 0; p < NUM_POOLS; p++) wr_idx[p] = nidx[p];
      if (!policy_split) begin
         if (hit[POOL_ARR]) begin
            repaired = 1'b1;
         end else if (!empty[POOL_ARR]) begin
            repaired         = 1'b1;
            take[POOL_ARR]   = acc;
            wr_en[POOL_ARR]  = acc;
            wr_en[POOL_PER]  = acc;
            wr_idx[POOL_PER] = nidx[POOL_ARR];
         end
      end else if (dfx_periph) begin
         if (hit[POOL_PER]) begin
            repaired = 1'b1;
         end else if (!empty[POOL_PER]) begin
            repaired        = 1'b1;
            take[POOL_PER]  = acc;
            wr_en[POOL_PER] = acc;
         end
      end else begin
         if (hit[POOL_ARR]) begin
            repaired = 1'b1;
         end else if (!empty[POOL_ARR]) begin
            repaired        = 1'b1;
            take[POOL_ARR]  = acc;
            wr_en[POOL_ARR] = acc;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         closed_q    <= 1'b0;
         res_valid_q <= 1'b0;
         res_rep_q   <= 1'b0;
         done_q      <= 1'b0;
         unrep_q     <= '0;
      end else begin
         res_valid_q <= acc;
         res_rep_q   <= acc && repaired;
         done_q      <= acc && dfx_last;
         if (acc && dfx_last) closed_q <= 1'b1;
         if (acc && !repaired && unrep_q != '1) unrep_q <= unrep_q + 1'b1;
      end
   end

   assign res_valid    = res_valid_q;
   assign res_repaired = res_rep_q;
   assign done         = done_q;
   assign unrep_cnt    = unrep_q;
   assign used_arr     = used[POOL_ARR];
   assign used_per     = used[POOL_PER];
   assign lk_arr_valid = lk_v[POOL_ARR];
   assign lk_arr_idx   = lk_i[POOL_ARR];
   assign lk_per_valid = lk_v[POOL_PER];
   assign lk_per_idx   = lk_i[POOL_PER];

   rr_bypass_steer #(.DW(DW)) u_byp (
      .mode   (byp_mode),
      .io_din (io_din),
      .wd_out (wd_out),
      .sa_out (sa_out),
      .dq_out (dq_out)
   );
endmodule

// File: rtl/rr_repair_alloc_chk.sv
module rr_repair_alloc_chk #(
   parameter int NUM_COLS    = 512,
   parameter int SPARE_RATIO = 32,
   parameter int DW          = 32,
   localparam int NSP        = NUM_COLS / SPARE_RATIO,
   localparam int CW         = $clog2(NUM_COLS),
   localparam int CNTW       = $clog2(NSP + 1),
   localparam int UW         = CW + 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            policy_split,
   input logic            dfx_valid,
   input logic            dfx_ready,
   input logic            res_valid,
   input logic            res_repaired,
   input logic            done,
   input logic [CNTW-1:0] used_arr,
   input logic [CNTW-1:0] used_per,
   input logic [UW-1:0]   unrep_cnt,
   input logic [1:0]      byp_mode,
   input logic [DW-1:0]   io_din,
   input logic [DW-1:0]   wd_out,
   input logic [DW-1:0]   sa_out,
   input logic [DW-1:0]   dq_out
);
   logic acc;
   assign acc = dfx_valid && dfx_ready;

   assert_result_due_R1: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> res_valid);
   assert_no_stray_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !res_valid);
   assert_idle_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> ($stable(used_arr) && $stable(used_per)));
   assert_tied_keeps_periph_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !policy_split) |=> $stable(used_per));
   assert_unrep_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_repaired) |-> (unrep_cnt == $past(unrep_cnt) + 1'b1));
   assert_pool_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (used_arr <= CNTW'(NSP)) && (used_per <= CNTW'(NSP)));
   assert_done_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (res_valid && !dfx_ready));
   assert_byp_io_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_mode == 2'd1) |-> (dq_out == io_din));
   assert_byp_periph_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_mode == 2'd2) |-> (dq_out == wd_out));
   assert_byp_normal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_mode == 2'd0 || byp_mode == 2'd3) |-> (dq_out == sa_out));
endmodule

bind rr_repair_alloc rr_repair_alloc_chk #(
   .NUM_COLS(NUM_COLS), .SPARE_RATIO(SPARE_RATIO), .DW(DW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .policy_split(policy_split),
   .dfx_valid(dfx_valid), .dfx_ready(dfx_ready),
   .res_valid(res_valid), .res_repaired(res_repaired), .done(done),
   .used_arr(used_arr), .used_per(used_per), .unrep_cnt(unrep_cnt),
   .byp_mode(byp_mode), .io_din(io_din), .wd_out(wd_out),
   .sa_out(sa_out), .dq_out(dq_out)
);

// File: tb/tb_rr_repair_alloc.sv
`timescale 1ns/1ps
module tb_rr_repair_alloc;
   localparam int NC  = 512;
   localparam int NSP = 16;
   localparam int CW  = 9;
   localparam int SW  = 4;
   localparam int CNTW = 5;
   localparam int UW  = 10;
   localparam int DW  = 32;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, policy_split, dfx_valid, dfx_ready, dfx_periph, dfx_last;
   logic [CW-1:0] dfx_col, lk_col;
   logic res_valid, res_repaired, done;
   logic [CNTW-1:0] used_arr, used_per;
   logic [UW-1:0] unrep_cnt;
   logic lk_arr_valid, lk_per_valid;
   logic [SW-1:0] lk_arr_idx, lk_per_idx;
   logic [1:0] byp_mode;
   logic [DW-1:0] io_din, wd_out, sa_out, dq_out;

   rr_repair_alloc dut (
      .clk(clk), .rst_n(rst_n), .policy_split(policy_split),
      .dfx_valid(dfx_valid), .dfx_ready(dfx_ready), .dfx_col(dfx_col),
      .dfx_periph(dfx_periph), .dfx_last(dfx_last),
      .res_valid(res_valid), .res_repaired(res_repaired), .done(done),
      .used_arr(used_arr), .used_per(used_per), .unrep_cnt(unrep_cnt),
      .lk_col(lk_col), .lk_arr_valid(lk_arr_valid), .lk_arr_idx(lk_arr_idx),
      .lk_per_valid(lk_per_valid), .lk_per_idx(lk_per_idx),
      .byp_mode(byp_mode), .io_din(io_din), .wd_out(wd_out),
      .sa_out(sa_out), .dq_out(dq_out)
   );

   int total = 0, bad = 0;
   bit finished = 0;

   typedef struct { bit rep; bit last; } exp_t;
   exp_t q[$];

   bit m_arr [NC];
   bit m_per [NC];
   int m_arr_idx [NC];
   int m_per_idx [NC];
   int m_arr_used, m_per_used, m_unrep;

   task automatic chk(string tag, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < NC; i++) begin
         m_arr[i] = 0; m_per[i] = 0; m_arr_idx[i] = 0; m_per_idx[i] = 0;
      end
      m_arr_used = 0; m_per_used = 0; m_unrep = 0;
   endtask

   task automatic do_reset(bit split);
      rst_n = 1'b0; dfx_valid = 1'b0; dfx_last = 1'b0; dfx_periph = 1'b0;
      dfx_col = '0; lk_col = '0; policy_split = split;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      model_clear();
   endtask

   task automatic send(int col, bit per, bit last);
      bit rep = 0;
      if (!policy_split) begin
         if (m_arr[col]) rep = 1;
         else if (m_arr_used < NSP) begin
            m_arr[col] = 1; m_arr_idx[col] = m_arr_used;
            m_per[col] = 1; m_per_idx[col] = m_arr_used;
            m_arr_used++; rep = 1;
         end
      end else if (per) begin
         if (m_per[col]) rep = 1;
         else if (m_per_used < NSP) begin
            m_per[col] = 1; m_per_idx[col] = m_per_used; m_per_used++; rep = 1;
         end
      end else begin
         if (m_arr[col]) rep = 1;
         else if (m_arr_used < NSP) begin
            m_arr[col] = 1; m_arr_idx[col] = m_arr_used; m_arr_used++; rep = 1;
         end
      end
      if (!rep) m_unrep++;
      q.push_back('{rep: rep, last: last});
      dfx_valid = 1'b1; dfx_col = CW'(col); dfx_periph = per; dfx_last = last;
      @(negedge clk);
      dfx_valid = 1'b0; dfx_last = 1'b0;
   endtask

   task automatic check_counts(string tag);
      chk({tag, " used_arr"}, used_arr, m_arr_used);
      chk({tag, " used_per"}, used_per, m_per_used);
      chk({tag, " unrep_cnt"}, unrep_cnt, m_unrep);
   endtask

   task automatic look(int col, string tag);
      lk_col = CW'(col);
      @(negedge clk);
      chk({tag, " arr valid"}, lk_arr_valid, m_arr[col]);
      if (m_arr[col]) chk({tag, " arr idx"}, lk_arr_idx, m_arr_idx[col]);
      chk({tag, " per valid"}, lk_per_valid, m_per[col]);
      if (m_per[col]) chk({tag, " per idx"}, lk_per_idx, m_per_idx[col]);
   endtask

   // monitor: pops the scoreboard on every result
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (q.size() == 0) begin
            chk("R1 result with no defect pending", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk("R5 res_repaired", res_repaired, e.rep);
            chk("R8 done with result", done, e.last);
         end
      end else if (rst_n && done) begin
         chk("R8 done without result", 1, 0);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      byp_mode = 2'd0; io_din = 32'h1111_0001; wd_out = 32'h2222_0002; sa_out = 32'h3333_0003;

      // R9 reset state
      do_reset(1'b1);
      chk("R9 dfx_ready", dfx_ready, 1);
      chk("R9 res_valid", res_valid, 0);
      chk("R9 done", done, 0);
      check_counts("R9");
      look(5, "R9 lookup");

      // R2 R3 split pools
      send(5, 0, 0);
      send(5, 1, 0);
      send(5, 0, 0);
      send(9, 1, 0);
      check_counts("R3 split same column");
      look(5, "R7 R3 col5");
      look(9, "R7 R2 col9");

      // R5 R6 exhaust the column pool, peripheral pool still serves
      for (int c = 100; c < 116; c++) send(c, 0, 0);
      check_counts("R6 column pool exhausted");
      chk("R6 used_arr at capacity", used_arr, NSP);
      send(115, 1, 0);
      look(115, "R5 no entry for unrepaired");
      look(114, "R2 last column spare");

      // R8 final marker
      send(200, 0, 1);
      chk("R8 ready low after last", dfx_ready, 0);
      dfx_valid = 1'b1; dfx_col = CW'(300); dfx_periph = 1'b1;
      repeat (2) @(negedge clk);
      dfx_valid = 1'b0;
      @(negedge clk);
      check_counts("R8 ignored after last");

      // R4 tied policy
      do_reset(1'b0);
      send(3, 1, 0);
      send(3, 0, 0);
      check_counts("R4 tied one spare");
      look(3, "R4 tied lookup");
      for (int c = 20; c < 36; c++) send(c, c % 2 == 1, 0);
      check_counts("R4 R5 tied exhaustion");
      chk("R4 peripheral pool untouched", used_per, 0);
      look(34, "R4 tied col34");
      look(35, "R5 tied col35 unrepaired");

      // R10 bypass steering
      for (int m = 0; m < 4; m++) begin
         byp_mode = 2'(m);
         #1;
         case (m)
            1: chk("R10 mode 01", dq_out, io_din);
            2: chk("R10 mode 10", dq_out, wd_out);
            default: chk("R10 mode 00/11", dq_out, sa_out);
         endcase
         @(negedge clk);
      end

      repeat (2) @(negedge clk);
      chk("R1 scoreboard drained", q.size(), 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule